// File: doc/BRIEF.md
# Multi-Cycle 16-bit Accumulating Core

This block is a small sequential processor with a 16-bit datapath, four general registers and a 10-bit program counter. It steps each instruction through a fixed series of states: read the instruction word at the PC, latch it while advancing the PC, decode it, read the operand word, compute, then write the result back to a register or to memory. It then starts over at the new PC.

The core talks to one shared program-and-data memory of 1024 sixteen-bit words through a synchronous port. A read returns data one clock after the address is driven. A write takes effect at the clock edge that sees the write strobe. The current PC, the four register values and a stop flag are brought out so that a test environment can follow execution.

Top module: `mc16_core`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, the PC reads 0, all four registers read 0, the stop flag is low and the memory write strobe is low.
- R2: An instruction word holds the opcode in bits [15:12], the register number (0 to 3) in bits [11:10] and a 10-bit word address in bits [9:0].
- R3: Opcode 0001 copies the memory word at the address into the selected register. From the edge that leaves the fetch state to the next fetch, it takes 7 clock cycles.
- R4: Opcode 0011 adds the memory word at the address to the selected register. The sum is taken modulo 2^16 with no carry kept, and the instruction takes 7 cycles.
- R5: Opcode 0010 writes the selected register to the addressed memory word. The write strobe is high for exactly one cycle, and the instruction takes 5 cycles.
- R6: Opcode 0000 stops the core. It takes 3 cycles to reach the stopped state. After that the stop flag stays high, the PC and registers hold, and no memory write occurs until reset.
- R7: Any opcode other than 0000 to 0011 changes no register and no memory word. It takes 3 cycles and advances the PC by one.
- R8: The PC advances by one per instruction and wraps from 0x3FF to 0x000.
- R9: A word written by a store is seen by the very next instruction fetch or operand read of that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 10 | Word address for instruction, operand or store |
| mem_we | output | 1 | Write strobe, high for one cycle during a store |
| mem_wdata | output | 16 | Register value written during a store |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| halted | output | 1 | High once a stop instruction has executed |
| dbg_pc | output | 10 | Current program counter |
| dbg_regs | output | 64 | Registers 0 to 3, register n in bits [16n+15:16n] |

## Verification
The write-back of a store and the fetch of the next instruction fall on adjacent edges. Both use the same memory port, so a store that targets the following instruction word, or a later operand, must hand over its data with no stale read. The bench provokes this with code that rewrites its own next instruction. It also runs a long run of no-ops that wraps the PC onto a word rewritten by a store at 0x3FE. It judges the result from the final register values, the PC and the exact cycle count to the stop.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_STOP  = 4'h0;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h3;

  typedef enum logic [2:0] {
    ST_FETCH   = 3'd0,
    ST_LATCH   = 3'd1,
    ST_DECODE  = 3'd2,
    ST_OPADDR  = 3'd3,
    ST_OPLATCH = 3'd4,
    ST_EXEC    = 3'd5,
    ST_WBACK   = 3'd6,
    ST_STOP    = 3'd7
  } seq_state_t;

endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2,
  localparam int NREGS = 1 << SEL_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wen,
  input  logic [SEL_W-1:0]        wsel,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [SEL_W-1:0]        rsel,
  output logic [DATA_W-1:0]       rdata,
  output logic [NREGS*DATA_W-1:0] flat
);

  logic [DATA_W-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (wen && (wsel == SEL_W'(g))) begin
        regs[g] <= wdata;
      end
    end
    assign flat[g*DATA_W +: DATA_W] = regs[g];
  end

  assign rdata = regs[rsel];

  // R3/R4: registers only change on a write-back
  p_regs_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !wen |=> $stable(flat));

endmodule

// File: rtl/mc16_alu.sv
module mc16_alu #(
  parameter int DATA_W = 16
) (
  input  logic              do_add,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, acc} + {1'b0, opnd};
    result   = do_add ? wide_sum[DATA_W-1:0] : opnd;
  end

endmodule

// File: rtl/mc16_seq.sv
module mc16_seq
  import mc16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] alu_result,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rf_wen,
  output logic [SEL_W-1:0]  rf_sel,
  output logic              alu_add,
  output logic [DATA_W-1:0] alu_opnd,
  output logic [ADDR_W-1:0] pc,
  output logic              halted
);

  seq_state_t        state;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] opnd_q;
  logic [DATA_W-1:0] res_q;

  logic [OPC_W-1:0]  opc;
  logic [ADDR_W-1:0] iaddr;
  logic              is_store;
  logic              is_regwr;

  always_comb begin
    opc      = ir[DATA_W-1 -: OPC_W];
    rf_sel   = ir[ADDR_W +: SEL_W];
    iaddr    = ir[ADDR_W-1:0];
    is_store = (opc == OPC_STORE);
    is_regwr = (opc == OPC_LOAD) || (opc == OPC_ADD);
  end

  always_comb begin
    mem_addr  = (state == ST_FETCH) ? pc : iaddr;
    mem_we    = (state == ST_WBACK) && is_store;
    mem_wdata = reg_rdata;
    rf_wen    = (state == ST_WBACK) && is_regwr;
    alu_add   = (opc == OPC_ADD);
    alu_opnd  = opnd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FETCH;
      pc     <= '0;
      ir     <= '0;
      opnd_q <= '0;
      res_q  <= '0;
      halted <= 1'b0;
    end else begin
      case (state)
        ST_FETCH: state <= ST_LATCH;
        ST_LATCH: begin
          ir    <= mem_rdata;
          pc    <= pc + 1'b1;
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          if (opc == OPC_STOP) begin
            halted <= 1'b1;
            state  <= ST_STOP;
          end else if (is_regwr) begin
            state <= ST_OPADDR;
          end else if (is_store) begin
            state <= ST_EXEC;
          end else begin
            state <= ST_FETCH;
          end
        end
        ST_OPADDR: state <= ST_OPLATCH;
        ST_OPLATCH: begin
          opnd_q <= mem_rdata;
          state  <= ST_EXEC;
        end
        ST_EXEC: begin
          res_q <= alu_result;
          state <= ST_WBACK;
        end
        ST_WBACK: state <= ST_FETCH;
        ST_STOP:  state <= ST_STOP;
        default:  state <= ST_FETCH;
      endcase
    end
  end

  // result register feeds the register file write port
  logic [DATA_W-1:0] unused_res;
  assign unused_res = res_q;

  // R5: the write strobe never lasts two cycles
  p_we_single_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R6: the stop flag is sticky and blocks further writes
  p_halt_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  p_halt_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_we && !rf_wen));
  p_halt_pc_hold_r6: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc));

  // R8: the PC moves only by one, only after the instruction latch
  p_pc_step_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LATCH) |=> (pc == $past(pc) + 1'b1));
  p_pc_still_r8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_LATCH) |=> $stable(pc));

endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int SEL_W  = 2,
  localparam int NREGS = 1 << SEL_W
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_we,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    halted,
  output logic [ADDR_W-1:0]       dbg_pc,
  output logic [NREGS*DATA_W-1:0] dbg_regs
);

  logic              rf_wen;
  logic [SEL_W-1:0]  rf_sel;
  logic [DATA_W-1:0] rf_rdata;
  logic              alu_add;
  logic [DATA_W-1:0] alu_opnd;
  logic [DATA_W-1:0] alu_result;
  logic [DATA_W-1:0] wb_data;

  mc16_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .mem_rdata  (mem_rdata),
    .reg_rdata  (rf_rdata),
    .alu_result (alu_result),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .rf_wen     (rf_wen),
    .rf_sel     (rf_sel),
    .alu_add    (alu_add),
    .alu_opnd   (alu_opnd),
    .pc         (dbg_pc),
    .halted     (halted)
  );

  assign wb_data = u_seq.res_q;

  mc16_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .wen   (rf_wen),
    .wsel  (rf_sel),
    .wdata (wb_data),
    .rsel  (rf_sel),
    .rdata (rf_rdata),
    .flat  (dbg_regs)
  );

  mc16_alu #(.DATA_W(DATA_W)) u_alu (
    .do_add (alu_add),
    .acc    (rf_rdata),
    .opnd   (alu_opnd),
    .result (alu_result)
  );

  // R1: nothing is written on the cycle reset is released
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!mem_we && !halted && dbg_pc == '0));

endmodule

// File: tb/tb_mc16_core.sv
module tb_mc16_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        halted;
  logic [9:0]  dbg_pc;
  logic [63:0] dbg_regs;

  logic [15:0] mem [1024];
  int checks = 0;
  int errors = 0;
  int cyc;
  int we_cnt;
  bit done = 0;

  always #4ns clk = ~clk;

  mc16_core dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted),
    .dbg_pc(dbg_pc), .dbg_regs(dbg_regs)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    if (rst) begin
      cyc <= 0;
      we_cnt <= 0;
    end else begin
      if (!halted) cyc <= cyc + 1;
      if (mem_we) we_cnt <= we_cnt + 1;
    end
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [1:0] r,
                                      input logic [9:0] a);
    return {op, r, a};
  endfunction

  function automatic logic [15:0] rg(input int n);
    return dbg_regs[n*16 +: 16];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [15:0] v);
    for (int i = 0; i < 1024; i++) mem[i] <= v;
    @(negedge clk);
  endtask

  task automatic put(input int a, input logic [15:0] v);
    mem[a] <= v;
    @(negedge clk);
  endtask

  task automatic start();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_halt(input string req);
    int n = 0;
    while (!halted && n < 6000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " stop reached"}, {31'd0, halted}, 32'd1);
  endtask

  // {register, a, b}
  localparam logic [33:0] VEC [8] = '{
    {2'd0, 16'h0001, 16'h0002},
    {2'd1, 16'h7FFF, 16'h0001},
    {2'd2, 16'hFFFF, 16'h0001},
    {2'd3, 16'h8000, 16'h8000},
    {2'd1, 16'h1234, 16'hEDCC},
    {2'd2, 16'hFFFE, 16'hFFFF},
    {2'd3, 16'h0000, 16'h0000},
    {2'd0, 16'hA5A5, 16'h0F0F}
  };

  initial begin
    // R1: reset state
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 pc", 32'(dbg_pc), 32'd0);
    chk("R1 regs", dbg_regs[31:0] | dbg_regs[63:32], 32'd0);
    chk("R1 halted/we", {30'd0, halted, mem_we}, 32'd0);

    // R2/R3/R4/R5: vector table, load-add-store-stop program
    for (int v = 0; v < 8; v++) begin
      logic [1:0]  r;
      logic [15:0] a, b, s;
      r = VEC[v][33:32];
      a = VEC[v][31:16];
      b = VEC[v][15:0];
      s = a + b;
      fill(16'h0000);
      put(0, ins(4'h1, r, 10'h100));
      put(1, ins(4'h3, r, 10'h101));
      put(2, ins(4'h2, r, 10'h102));
      put(3, 16'h0000);
      put(10'h100, a);
      put(10'h101, b);
      start();
      wait_halt("R4");
      chk("R4 sum in register", 32'(rg(int'(r))), 32'(s));
      chk("R5 stored word", 32'(mem[10'h102]), 32'(s));
      chk("R5 one strobe", 32'(we_cnt), 32'd1);
      chk("R3 cycles load+add+store+stop", 32'(cyc), 32'd22);
      chk("R2 pc after four words", 32'(dbg_pc), 32'd4);
    end

    // R1: reset after a run clears state
    rst = 1'b1;
    @(negedge clk);
    chk("R1 rerun reset regs", dbg_regs[31:0] | dbg_regs[63:32], 32'd0);
    chk("R1 rerun reset flag", {31'd0, halted}, 32'd0);

    // R3: single load timing
    fill(16'h0000);
    put(0, ins(4'h1, 2'd3, 10'h3FF));
    put(1, 16'h0000);
    put(10'h3FF, 16'hC0DE);
    start();
    wait_halt("R3");
    chk("R3 load value", 32'(rg(3)), 32'h0000C0DE);
    chk("R3 load cycles", 32'(cyc), 32'd10);

    // R7: undefined opcodes do nothing
    fill(16'h0000);
    put(0, 16'h9000);
    put(1, 16'hF3FF);
    put(2, 16'h0000);
    put(10'h3FF, 16'h7777);
    start();
    wait_halt("R7");
    chk("R7 regs untouched", dbg_regs[31:0] | dbg_regs[63:32], 32'd0);
    chk("R7 no writes", 32'(we_cnt), 32'd0);
    chk("R7 pc", 32'(dbg_pc), 32'd3);
    chk("R7 cycles", 32'(cyc), 32'd9);

    // R6: stop holds everything
    fill(16'h0000);
    put(0, 16'h0000);
    put(1, ins(4'h1, 2'd1, 10'h100));
    put(2, ins(4'h2, 2'd1, 10'h101));
    put(10'h100, 16'h5555);
    start();
    wait_halt("R6");
    repeat (20) @(negedge clk);
    chk("R6 flag sticky", {31'd0, halted}, 32'd1);
    chk("R6 pc held", 32'(dbg_pc), 32'd1);
    chk("R6 reg not loaded", 32'(rg(1)), 32'd0);
    chk("R6 no writes", 32'(we_cnt), 32'd0);
    chk("R6 cycles", 32'(cyc), 32'd3);

    // R9: store rewrites the next instruction word
    fill(16'h0000);
    put(0, ins(4'h1, 2'd3, 10'h020));
    put(1, ins(4'h2, 2'd3, 10'h002));
    put(2, 16'h0000);
    put(3, 16'h0000);
    put(10'h020, ins(4'h3, 2'd0, 10'h200));
    put(10'h200, 16'h1234);
    start();
    wait_halt("R9");
    chk("R9 rewritten word executed", 32'(rg(0)), 32'h00001234);
    chk("R9 pc", 32'(dbg_pc), 32'd4);

    // R8: PC wrap onto a word rewritten by a store at 0x3FE
    fill(16'hF000);
    put(10'h3FE, ins(4'h2, 2'd0, 10'h000));
    start();
    wait_halt("R8");
    chk("R8 pc after wrap", 32'(dbg_pc), 32'd1);
    chk("R8 word zero rewritten", 32'(mem[0]), 32'd0);
    chk("R8 cycles", 32'(cyc), 32'd3077);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8ns * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule